// File: doc/BRIEF.md
# Conversion Result Formatter and Serializer

This block takes a signed conversion result and sends it out as a serial stream of bytes. A load strobe captures the result into a holding register. At that moment the block applies the selected output code and an optional clamp that keeps only non-negative values. It then shifts the requested number of bytes out, one bit per cycle in which the serial clock enable is high. Byte order, bit order within each byte, and the output pin are all set by configuration inputs. The configuration is sampled together with the result, so inputs that change during a transfer do not affect it.

The stored result is seen as a small byte-addressed register. Address 0 holds the most significant byte, address 1 the middle byte, and address 2 the least significant byte. Address 3 reads as zero. Addresses wrap modulo 4. A transfer starts at the given start address and then steps up or down through the addresses, depending on the byte-order setting.

Top module: `rfs_serializer`

## Requirements
- R1: With `fmt_offset_i`=0 (two's complement), the code sent equals the 24-bit result: positive full scale is 7FFFFF, zero is 000000 and negative full scale is 800000.
- R2: With `fmt_offset_i`=1 (offset binary), the code sent is the two's complement code with its most significant bit inverted: positive full scale is FFFFFF, zero is 800000 and negative full scale is 000000.
- R3: With `unipolar_i`=1, a negative result is replaced by the zero code of the selected format (000000 or 800000), and a non-negative result is sent unchanged. The full-scale mapping stays the same.
- R4: With `unipolar_i`=0, negative results are sent without any limit.
- R5: With `byte_rev_i`=0, the first byte sent is the byte at `start_addr_i`, and each later byte comes from the next higher address, modulo 4. Address 0 is bits 23:16, address 1 is bits 15:8, address 2 is bits 7:0, and address 3 reads as 00.
- R6: With `byte_rev_i`=1, each later byte comes from the next lower address, modulo 4, using the same address map.
- R7: With `bit_rev_i`=0, each byte is sent most significant bit first. With `bit_rev_i`=1, it is sent least significant bit first.
- R8: With `pin_ded_i`=0, only `oe_shared_o` may assert, and `oe_ded_o` stays 0 at all times. With `pin_ded_i`=1, only `oe_ded_o` may assert. Either enable is high only while `busy_o` is high. `sdo_o` is 0 whenever the block is idle.
- R9: The bit position advances only on cycles in which `busy_o` and `sclk_en_i` are both high. While the enable is low, `sdo_o` holds its value.
- R10: A load strobe seen while idle starts a transfer of `nbytes_m1_i`+1 bytes. `busy_o` rises in the next cycle and falls after the last bit of the last byte. A load strobe, a new result or a new configuration arriving while busy has no effect on the transfer in progress.
- R11: After reset, `busy_o`, `sdo_o`, `oe_shared_o` and `oe_ded_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_i | input | 24 | Signed conversion result |
| load_i | input | 1 | Capture the result and start a transfer (honoured only when idle) |
| fmt_offset_i | input | 1 | 0: two's complement, 1: offset binary |
| unipolar_i | input | 1 | 1: replace negative results with the zero code |
| byte_rev_i | input | 1 | 0: addresses step up, 1: addresses step down |
| bit_rev_i | input | 1 | 0: MSB first within each byte, 1: LSB first |
| pin_ded_i | input | 1 | 0: shared data pin, 1: dedicated output pin |
| start_addr_i | input | 2 | Address of the first byte sent |
| nbytes_m1_i | input | 2 | Number of bytes to send, minus one |
| sclk_en_i | input | 1 | Shift enable, one bit per enabled cycle |
| sdo_o | output | 1 | Serial data bit |
| oe_shared_o | output | 1 | Output enable for the shared bidirectional pin |
| oe_ded_o | output | 1 | Output enable for the dedicated output pin |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The bench drives both full-scale codes and zero in each format, because a formatter that inverts the wrong bit or clamps to literal zero rather than the format's zero code would send 000000 where 800000 belongs. Transfers start at address 1 or 0 and run into address 3 and across the wrap in both directions; a serializer with the wrong address direction, or with a missing wrap, would send the wrong bytes in sequence or stop early. The enable is toggled at random, so a shifter that advances without it drops bits. While a transfer is running, the bench changes the result and configuration and raises load again; a design that captures them would corrupt the rest of the stream or extend `busy_o`.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef struct packed {
    logic offset;
    logic unipolar;
    logic byte_rev;
    logic bit_rev;
    logic pin_ded;
  } out_cfg_t;
endpackage

// File: rtl/rfs_format.sv
module rfs_format #(
  parameter int W = 24
) (
  input  logic [W-1:0]        res_i,
  input  rfs_pkg::out_cfg_t   cfg_i,
  output logic [W-1:0]        code_o
);
  // clamp first, then choose the code: both zero codes fall out naturally
  function automatic logic [W-1:0] fmt_code(logic [W-1:0] r, logic off, logic uni);
    logic [W-1:0] c;
    c = (uni && r[W-1]) ? '0 : r;
    if (off) c[W-1] = ~c[W-1];
    return c;
  endfunction

  assign code_o = fmt_code(res_i, cfg_i.offset, cfg_i.unipolar);
endmodule

// File: rtl/rfs_byte_sel.sv
module rfs_byte_sel #(
  parameter int W  = 24,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic [W-1:0]  word_i,
  input  logic [AW-1:0] addr_i,
  output logic [BW-1:0] byte_o
);
  localparam int NBYTES = W / BW;
  localparam int NSLOT  = 1 << AW;

  logic [BW-1:0] slot [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < NBYTES) begin : g_data
      assign slot[i] = word_i[W-1-i*BW -: BW];
    end else begin : g_empty
      assign slot[i] = '0;
    end
  end

  assign byte_o = slot[addr_i];
endmodule

// File: rtl/rfs_shifter.sv
module rfs_shifter #(
  parameter int W  = 24,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    sclk_en_i,
  input  logic [W-1:0]            code_i,
  input  rfs_pkg::out_cfg_t       cfg_i,
  input  logic [AW-1:0]           start_addr_i,
  input  logic [AW-1:0]           nbytes_m1_i,
  output logic                    busy_o,
  output logic [W-1:0]            hold_o,
  output rfs_pkg::out_cfg_t       cfg_o,
  output logic [AW-1:0]           addr_o,
  output logic [$clog2(BW)-1:0]   bitcnt_o
);
  localparam int BIT_W = $clog2(BW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BW - 1);

  logic                busy_q;
  logic [W-1:0]        hold_q;
  rfs_pkg::out_cfg_t   cfg_q;
  logic [AW-1:0]       addr_q;
  logic [AW-1:0]       left_q;
  logic [BIT_W-1:0]    bitcnt_q;

  // named events for assertions
  logic start_ev, step_ev, byte_end_ev, last_ev;
  assign start_ev    = load_i & ~busy_q;
  assign step_ev     = busy_q & sclk_en_i;
  assign byte_end_ev = step_ev && (bitcnt_q == LAST_BIT);
  assign last_ev     = byte_end_ev && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      hold_q   <= '0;
      cfg_q    <= '0;
      addr_q   <= '0;
      left_q   <= '0;
      bitcnt_q <= '0;
    end else if (start_ev) begin
      busy_q   <= 1'b1;
      hold_q   <= code_i;
      cfg_q    <= cfg_i;
      addr_q   <= start_addr_i;
      left_q   <= nbytes_m1_i;
      bitcnt_q <= '0;
    end else if (step_ev) begin
      if (bitcnt_q == LAST_BIT) begin
        bitcnt_q <= '0;
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
          addr_q <= cfg_q.byte_rev ? addr_q - 1'b1 : addr_q + 1'b1;
        end
      end else begin
        bitcnt_q <= bitcnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign hold_o   = hold_q;
  assign cfg_o    = cfg_q;
  assign addr_o   = addr_q;
  assign bitcnt_o = bitcnt_q;

  // R10: captured data survives the whole transfer
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_ev) |=> ($stable(hold_q) && $stable(cfg_q)));
  // R10: busy ends right after the final bit
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> !busy_q);
  // R9: no progress without the shift enable
  p_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sclk_en_i) |=> ($stable(bitcnt_q) && $stable(addr_q)));
  // R5: ascending address walk
  p_addr_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_ev && !last_ev && !cfg_q.byte_rev) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
  // R6: descending address walk
  p_addr_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_ev && !last_ev && cfg_q.byte_rev) |=> (addr_q == AW'($past(addr_q) - 1'b1)));
endmodule

// File: rtl/rfs_serializer.sv
module rfs_serializer #(
  parameter int W  = 24,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  res_i,
  input  logic          load_i,
  input  logic          fmt_offset_i,
  input  logic          unipolar_i,
  input  logic          byte_rev_i,
  input  logic          bit_rev_i,
  input  logic          pin_ded_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] nbytes_m1_i,
  input  logic          sclk_en_i,
  output logic          sdo_o,
  output logic          oe_shared_o,
  output logic          oe_ded_o,
  output logic          busy_o
);
  localparam int BIT_W = $clog2(BW);

  rfs_pkg::out_cfg_t cfg_in, cfg_q;
  logic [W-1:0]      fmt_code, hold;
  logic [AW-1:0]     addr;
  logic [BIT_W-1:0]  bitcnt;
  logic [BW-1:0]     cur_byte;
  logic [BIT_W-1:0]  bit_idx;
  logic              busy;

  assign cfg_in = '{offset: fmt_offset_i, unipolar: unipolar_i,
                    byte_rev: byte_rev_i, bit_rev: bit_rev_i, pin_ded: pin_ded_i};

  rfs_format #(.W(W)) u_fmt (
    .res_i(res_i), .cfg_i(cfg_in), .code_o(fmt_code)
  );

  rfs_shifter #(.W(W), .BW(BW), .AW(AW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .sclk_en_i(sclk_en_i),
    .code_i(fmt_code), .cfg_i(cfg_in), .start_addr_i(start_addr_i),
    .nbytes_m1_i(nbytes_m1_i), .busy_o(busy), .hold_o(hold), .cfg_o(cfg_q),
    .addr_o(addr), .bitcnt_o(bitcnt)
  );

  rfs_byte_sel #(.W(W), .BW(BW), .AW(AW)) u_sel (
    .word_i(hold), .addr_i(addr), .byte_o(cur_byte)
  );

  assign bit_idx     = cfg_q.bit_rev ? bitcnt : BIT_W'(BW - 1) - bitcnt;
  assign sdo_o       = busy & cur_byte[bit_idx];
  assign oe_shared_o = busy & ~cfg_q.pin_ded;
  assign oe_ded_o    = busy &  cfg_q.pin_ded;
  assign busy_o      = busy;

  // R8: never both pins driven
  p_oe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oe_shared_o, oe_ded_o}));
  // R8: enables only during a transfer
  p_oe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_shared_o || oe_ded_o) |-> busy_o);
  // R8: dedicated pin stays quiet when the shared pin is chosen
  p_ded_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.pin_ded |-> !oe_ded_o);
  // R3: clamped code never reads as negative in its format
  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unipolar_i |-> (fmt_code[W-1] == fmt_offset_i));
  // R9: output bit holds while the enable is low
  p_sdo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sclk_en_i) |=> $stable(sdo_o));
endmodule

// File: tb/tb_rfs_serializer.sv
module tb_rfs_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] res_i = '0;
  logic        load_i = 1'b0;
  logic        fmt_offset_i = 1'b0, unipolar_i = 1'b0, byte_rev_i = 1'b0;
  logic        bit_rev_i = 1'b0, pin_ded_i = 1'b0, sclk_en_i = 1'b0;
  logic [1:0]  start_addr_i = '0, nbytes_m1_i = '0;
  logic        sdo_o, oe_shared_o, oe_ded_o, busy_o;

  int total = 0, bad = 0;
  string cur_req = "R11";
  bit    q[$];
  bit    m_pin = 1'b0;
  bit    check_on = 1'b0;

  always #2 clk = ~clk;

  rfs_serializer dut (
    .clk(clk), .rst_n(rst_n), .res_i(res_i), .load_i(load_i),
    .fmt_offset_i(fmt_offset_i), .unipolar_i(unipolar_i), .byte_rev_i(byte_rev_i),
    .bit_rev_i(bit_rev_i), .pin_ded_i(pin_ded_i), .start_addr_i(start_addr_i),
    .nbytes_m1_i(nbytes_m1_i), .sclk_en_i(sclk_en_i), .sdo_o(sdo_o),
    .oe_shared_o(oe_shared_o), .oe_ded_o(oe_ded_o), .busy_o(busy_o)
  );

  function automatic int exp_code(int v, bit off, bit uni);
    if (uni && v < 0) v = 0;
    if (off) return v + 8388608;
    return v & 32'h00FF_FFFF;
  endfunction

  // reference model: queue of expected bits
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_pin <= 1'b0;
    end else if (q.size() > 0) begin
      if (sclk_en_i) void'(q.pop_front());
    end else if (load_i) begin
      int v, code, a, bv;
      v = int'($signed(res_i));
      code = exp_code(v, fmt_offset_i, unipolar_i);
      for (int k = 0; k <= int'(nbytes_m1_i); k++) begin
        a = byte_rev_i ? (int'(start_addr_i) - k) & 3 : (int'(start_addr_i) + k) & 3;
        bv = (a < 3) ? (code >> (8 * (2 - a))) & 255 : 0;
        for (int b = 0; b < 8; b++)
          q.push_back(bit_rev_i ? bv[b] : bv[7 - b]);
      end
      m_pin <= pin_ded_i;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (check_on) begin
      bit eb, ed;
      eb = (q.size() > 0);
      ed = eb ? q[0] : 1'b0;
      chk(busy_o == eb, "busy", busy_o, eb);
      chk(sdo_o == ed, "sdo", sdo_o, ed);
      chk(oe_shared_o == (eb && !m_pin), "oe_shared", oe_shared_o, eb && !m_pin);
      chk(oe_ded_o == (eb && m_pin), "oe_ded", oe_ded_o, eb && m_pin);
    end
  end

  task automatic run(string req, int v, bit off, bit uni, bit br, bit bitr, bit pin,
                     int sa, int n, int en_mode, bit disturb);
    int cyc = 0;
    @(negedge clk);
    cur_req = req;
    res_i = 24'(v); fmt_offset_i = off; unipolar_i = uni; byte_rev_i = br;
    bit_rev_i = bitr; pin_ded_i = pin; start_addr_i = 2'(sa); nbytes_m1_i = 2'(n);
    load_i = 1'b1; sclk_en_i = (en_mode == 0);
    @(negedge clk);
    load_i = 1'b0;
    while (q.size() > 0) begin
      cyc++;
      case (en_mode)
        0: sclk_en_i = 1'b1;
        1: sclk_en_i = 1'($urandom_range(0, 1));
        default: sclk_en_i = (cyc % 3 == 0);
      endcase
      if (disturb) begin
        res_i = 24'($urandom); load_i = 1'($urandom_range(0, 1));
        fmt_offset_i = ~off; unipolar_i = ~uni; byte_rev_i = ~br;
        bit_rev_i = ~bitr; pin_ded_i = ~pin; start_addr_i = 2'($urandom);
      end
      @(negedge clk);
    end
    load_i = 1'b0; sclk_en_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    chk(busy_o == 0 && sdo_o == 0 && oe_shared_o == 0 && oe_ded_o == 0,
        "reset outputs", {busy_o, sdo_o, oe_shared_o, oe_ded_o}, 0);
    rst_n = 1'b1;
    check_on = 1'b1;
    @(negedge clk);
    // R1 two's complement: +FS, zero, -FS
    run("R1", 8388607, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    run("R1", 0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    run("R1", -8388608, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    // R2 offset binary
    run("R2", 8388607, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    run("R2", 0, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    run("R2", -8388608, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    // R3 unipolar clamp in both formats, positive passes
    run("R3", -12345, 0, 1, 0, 0, 0, 0, 2, 0, 0);
    run("R3", -1, 1, 1, 0, 0, 0, 0, 2, 0, 0);
    run("R3", 8388607, 1, 1, 0, 0, 0, 0, 2, 0, 0);
    // R4 bipolar negative
    run("R4", -1234567, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    run("R4", -5, 1, 0, 0, 0, 0, 0, 2, 0, 0);
    // R5 ascending with empty slot and wrap
    run("R5", 24'h00A5C3, 0, 0, 0, 0, 0, 1, 3, 0, 0);
    run("R5", 1193046, 0, 0, 0, 0, 0, 2, 2, 0, 0);
    // R6 descending with wrap
    run("R6", 1193046, 0, 0, 1, 0, 0, 2, 2, 0, 0);
    run("R6", -3000000, 1, 0, 1, 0, 0, 0, 3, 0, 0);
    // R7 bit order
    run("R7", 24'h0F3901, 0, 0, 0, 1, 0, 0, 2, 0, 0);
    run("R7", 24'h0F3901, 0, 0, 1, 1, 0, 2, 1, 0, 0);
    // R8 dedicated pin
    run("R8", 777777, 0, 0, 0, 0, 1, 0, 2, 0, 0);
    run("R8", 777777, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    // R9 gated shifting
    run("R9", -4194304, 0, 0, 0, 0, 0, 0, 2, 1, 0);
    run("R9", 2345678, 1, 1, 1, 1, 1, 2, 2, 2, 0);
    // R10 disturbance during transfer, and back-to-back loads
    run("R10", 3456789, 0, 0, 0, 0, 0, 0, 2, 1, 1);
    run("R10", -2222222, 1, 0, 1, 1, 1, 3, 3, 0, 1);
    run("R10", 42, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule